// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block moves data for a set of DMA channels whose registers are held outside it. When started, it scans the channels from index 0 upward. For each channel that is enabled, not halted and has elements left, it checks the channel's flow type against the peripheral request lines. It then copies elements one at a time until the channel stops qualifying, and only then moves to the next index. Each element is a read from the source address followed by a write of that word to the destination address. The addresses then step forward and the element count drops by one.

When a channel's count runs out, the engine does one of two things. If a descriptor pointer is set, it fetches a four-word descriptor and carries on with it. Otherwise it turns the channel off. After every element or descriptor fetch, the updated channel state goes out on one write-back port so that the outer register file can store it. Memory is reached through a single-word master port with a valid/ready handshake. A request stays asserted, with its address, direction and write data unchanged, until ready is seen high at a clock edge. Read data is taken in that same edge. Back-pressure is applied by holding ready low for as long as needed, and the engine never withdraws a request.

The engine is started by a kick pulse or by any change on the request lines. A start that arrives during a pass causes one more full pass once the current pass ends.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, busy, mem_valid and wb_valid are low and no tc_pulse or err_pulse bit is set.
- R2: While glb_en is low the engine makes no memory access. A kick given while glb_en is low is discarded, so enabling later starts nothing until a new start event.
- R3: A channel qualifies only when its configuration bit 0 (enable) is 1, its configuration bit 18 (halt) is 0 and its count, control bits [11:0], is nonzero. Otherwise it causes no memory access and keeps its state.
- R4: Channels are served lowest index first. A channel keeps moving elements while it still qualifies, and only then does the scan move on, so write-backs for one channel come before those of any higher channel in the same pass.
- R5: The flow type is configuration bits [13:11], the source peripheral id bits [5:1] and the destination peripheral id bits [10:6]. The request seen for an id is req_single OR req_burst at that bit position. Flow 0 always moves data, flow 1 needs the destination request, flow 2 needs the source request and flow 3 needs both.
- R6: A qualifying channel with flow type 4 or more gets a one-cycle err_pulse bit for its index. It makes no memory access.
- R7: An element reads the word at the source address and writes it to the destination address, with mem_size equal to control bits [20:18]. The source address advances by 1<<ctrl[20:18] bytes when control bit 26 is set, and the destination address advances by the same step when control bit 27 is set.
- R8: After each element, wb_valid pulses with the channel index, the new addresses and the control word with its count reduced by one. Control bits [31:12] are left unchanged.
- R9: When the count reaches zero and the descriptor pointer is nonzero, four words are read: the source from pointer+0, the destination from +4, the next pointer from +8 and the control word from +12. Service then continues with the new values.
- R10: When the count reaches zero and the descriptor pointer is zero, the write-back carries wb_en = 0.
- R11: When a count reaches zero and bit 31 of the control word that ran out is set, tc_pulse pulses for that channel in the cycle after its write-back.
- R12: A kick pulse or any change of req_single or req_burst starts a pass. A start event during a pass causes a further full pass from index 0.
- R13: mem_valid, mem_addr, mem_we and mem_wdata stay unchanged while mem_valid is high and mem_ready is low.
- R14: busy is high from the start of a pass until the engine returns to idle. While busy is low there are no memory requests and no write-backs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Global engine enable |
| kick | input | 1 | Start pulse |
| req_single | input | 32 | Single-transfer peripheral request lines |
| req_burst | input | 32 | Burst peripheral request lines |
| ch_src | input | NCH*32 | Source address of each channel, channel 0 in the low word |
| ch_dst | input | NCH*32 | Destination address of each channel |
| ch_lli | input | NCH*32 | Descriptor pointer of each channel |
| ch_ctrl | input | NCH*32 | Control word of each channel |
| ch_conf | input | NCH*32 | Configuration word of each channel |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request in this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 3 | log2 of the access size in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid when mem_ready is high for a read |
| wb_valid | output | 1 | Write-back strobe for channel state |
| wb_chan | output | log2(NCH) | Channel being written back |
| wb_src | output | 32 | Updated source address |
| wb_dst | output | 32 | Updated destination address |
| wb_lli | output | 32 | Updated descriptor pointer |
| wb_ctrl | output | 32 | Updated control word |
| wb_en | output | 1 | Updated enable bit |
| tc_pulse | output | NCH | Terminal-count pulse for each channel |
| err_pulse | output | NCH | Flow-type error pulse for each channel |
| busy | output | 1 | Engine is in a pass |

## Verification
The engine keeps a working copy of the active channel, so a wrong value there first appears on the memory address bus of the next element. It then reaches the write-back port within one element, which takes about four cycles without stalls. A wrong count or increment step therefore shows up as a bad final address or a wrong number of accesses. A wrong scan index or pass state shows up as write-backs out of order, or as a channel left enabled once busy falls. The tests check final register and memory contents after each pass, and they record the order of write-backs and pulses to catch both kinds of fault.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  localparam int WORD_W    = 32;
  localparam int REQ_LINES = 32;

  localparam int CF_EN     = 0;
  localparam int CF_HALT   = 18;
  localparam int CF_FLOW   = 11;
  localparam int CF_SID    = 1;
  localparam int CF_DID    = 6;
  localparam int CT_CNT_W  = 12;
  localparam int CT_WID    = 18;
  localparam int CT_SINC   = 26;
  localparam int CT_DINC   = 27;
  localparam int CT_TCREQ  = 31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_RD, ST_WR, ST_LINK, ST_WB, ST_CHK, ST_ADV
  } eng_st_e;

  function automatic logic conf_live(input logic [WORD_W-1:0] c);
    return c[CF_EN] && !c[CF_HALT];
  endfunction
endpackage

// File: rtl/dma_flow_gate.sv
module dma_flow_gate
  import dma_eng_pkg::*;
(
  input  logic [WORD_W-1:0]    conf,
  input  logic [REQ_LINES-1:0] req,
  output logic                 go,
  output logic                 bad
);
  logic [2:0] flow;
  logic       s_ok;
  logic       d_ok;

  always_comb begin
    flow = conf[CF_FLOW +: 3];
    s_ok = req[conf[CF_SID +: 5]];
    d_ok = req[conf[CF_DID +: 5]];
    bad  = flow[2];
    unique case (flow[1:0])
      2'd0:    go = !flow[2];
      2'd1:    go = !flow[2] && d_ok;
      2'd2:    go = !flow[2] && s_ok;
      default: go = !flow[2] && s_ok && d_ok;
    endcase
  end
endmodule

// File: rtl/dma_start_detect.sv
module dma_start_detect
  import dma_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 kick,
  input  logic [REQ_LINES-1:0] req_single,
  input  logic [REQ_LINES-1:0] req_burst,
  input  logic                 clr,
  output logic                 pend
);
  logic [REQ_LINES-1:0] s_q, b_q;
  logic                 evt;

  assign evt = kick || (req_single != s_q) || (req_burst != b_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= '0;
      b_q  <= '0;
      pend <= 1'b0;
    end else begin
      s_q  <= req_single;
      b_q  <= req_burst;
      pend <= (pend && !clr) || evt;
    end
  end

  assert_kick_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> pend);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int VW = NCH * WORD_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic                 kick,
  input  logic [REQ_LINES-1:0] req_single,
  input  logic [REQ_LINES-1:0] req_burst,
  input  logic [VW-1:0]        ch_src,
  input  logic [VW-1:0]        ch_dst,
  input  logic [VW-1:0]        ch_lli,
  input  logic [VW-1:0]        ch_ctrl,
  input  logic [VW-1:0]        ch_conf,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic                 mem_we,
  output logic [WORD_W-1:0]    mem_addr,
  output logic [2:0]           mem_size,
  output logic [WORD_W-1:0]    mem_wdata,
  input  logic [WORD_W-1:0]    mem_rdata,
  output logic                 wb_valid,
  output logic [CW-1:0]        wb_chan,
  output logic [WORD_W-1:0]    wb_src,
  output logic [WORD_W-1:0]    wb_dst,
  output logic [WORD_W-1:0]    wb_lli,
  output logic [WORD_W-1:0]    wb_ctrl,
  output logic                 wb_en,
  output logic [NCH-1:0]       tc_pulse,
  output logic [NCH-1:0]       err_pulse,
  output logic                 busy
);
  eng_st_e            st;
  logic [CW-1:0]      idx;
  logic [WORD_W-1:0]  w_src, w_dst, w_lli, w_ctrl, w_conf, dbuf, lnk_ptr;
  logic               w_en, tc_hit;
  logic [1:0]         lnk_k;
  logic               pend, pend_clr, last_idx;
  logic [WORD_W-1:0]  sel_src, sel_dst, sel_lli, sel_ctrl, sel_conf;
  logic               scan_go, scan_bad, work_go, work_bad;
  logic [WORD_W-1:0]  step;
  logic [CT_CNT_W-1:0] cnt_dec;
  logic               xfer;

  assign sel_src  = ch_src [idx*WORD_W +: WORD_W];
  assign sel_dst  = ch_dst [idx*WORD_W +: WORD_W];
  assign sel_lli  = ch_lli [idx*WORD_W +: WORD_W];
  assign sel_ctrl = ch_ctrl[idx*WORD_W +: WORD_W];
  assign sel_conf = ch_conf[idx*WORD_W +: WORD_W];

  dma_flow_gate u_scan_gate (
    .conf(sel_conf), .req(req_single | req_burst), .go(scan_go), .bad(scan_bad)
  );
  dma_flow_gate u_work_gate (
    .conf(w_conf), .req(req_single | req_burst), .go(work_go), .bad(work_bad)
  );

  assign last_idx = (idx == CW'(NCH - 1));
  assign pend_clr = (st == ST_IDLE) || (st == ST_ADV && last_idx);

  dma_start_detect u_start (
    .clk(clk), .rst_n(rst_n), .kick(kick), .req_single(req_single),
    .req_burst(req_burst), .clr(pend_clr), .pend(pend)
  );

  assign step    = WORD_W'(1) << w_ctrl[CT_WID +: 3];
  assign cnt_dec = w_ctrl[CT_CNT_W-1:0] - 1'b1;
  assign xfer    = mem_valid && mem_ready;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = w_src;
    mem_size  = w_ctrl[CT_WID +: 3];
    mem_wdata = dbuf;
    unique case (st)
      ST_RD: mem_valid = 1'b1;
      ST_WR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = w_dst;
      end
      ST_LINK: begin
        mem_valid = 1'b1;
        mem_addr  = lnk_ptr + {28'd0, lnk_k, 2'b00};
        mem_size  = 3'd2;
      end
      default: ;
    endcase
  end

  assign wb_valid = (st == ST_WB);
  assign wb_chan  = idx;
  assign wb_src   = w_src;
  assign wb_dst   = w_dst;
  assign wb_lli   = w_lli;
  assign wb_ctrl  = w_ctrl;
  assign wb_en    = w_en;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      idx       <= '0;
      w_src     <= '0;
      w_dst     <= '0;
      w_lli     <= '0;
      w_ctrl    <= '0;
      w_conf    <= '0;
      w_en      <= 1'b0;
      dbuf      <= '0;
      lnk_ptr   <= '0;
      lnk_k     <= '0;
      tc_hit    <= 1'b0;
      tc_pulse  <= '0;
      err_pulse <= '0;
    end else begin
      tc_pulse  <= '0;
      err_pulse <= '0;
      unique case (st)
        ST_IDLE: if (pend && glb_en) begin
          idx <= '0;
          st  <= ST_SCAN;
        end
        ST_SCAN: begin
          st <= ST_ADV;
          if (glb_en && conf_live(sel_conf)) begin
            if (scan_bad) begin
              err_pulse[idx] <= 1'b1;
            end else if (scan_go && sel_ctrl[CT_CNT_W-1:0] != '0) begin
              w_src  <= sel_src;
              w_dst  <= sel_dst;
              w_lli  <= sel_lli;
              w_ctrl <= sel_ctrl;
              w_conf <= sel_conf;
              w_en   <= 1'b1;
              st     <= ST_RD;
            end
          end
        end
        ST_RD: if (xfer) begin
          dbuf <= mem_rdata;
          st   <= ST_WR;
        end
        ST_WR: if (xfer) begin
          if (w_ctrl[CT_SINC]) w_src <= w_src + step;
          if (w_ctrl[CT_DINC]) w_dst <= w_dst + step;
          w_ctrl[CT_CNT_W-1:0] <= cnt_dec;
          st <= ST_WB;
          if (cnt_dec == '0) begin
            tc_hit <= w_ctrl[CT_TCREQ];
            if (w_lli != '0) begin
              lnk_ptr <= w_lli;
              lnk_k   <= '0;
              st      <= ST_LINK;
            end else begin
              w_en <= 1'b0;
            end
          end
        end
        ST_LINK: if (xfer) begin
          unique case (lnk_k)
            2'd0: w_src  <= mem_rdata;
            2'd1: w_dst  <= mem_rdata;
            2'd2: w_lli  <= mem_rdata;
            default: w_ctrl <= mem_rdata;
          endcase
          lnk_k <= lnk_k + 1'b1;
          if (lnk_k == 2'd3) st <= ST_WB;
        end
        ST_WB: begin
          tc_pulse[idx] <= tc_hit;
          tc_hit        <= 1'b0;
          st            <= ST_CHK;
        end
        ST_CHK: begin
          if (glb_en && w_en && !sel_conf[CF_HALT] && !work_bad && work_go &&
              w_ctrl[CT_CNT_W-1:0] != '0)
            st <= ST_RD;
          else
            st <= ST_ADV;
        end
        ST_ADV: begin
          if (!last_idx) begin
            idx <= idx + 1'b1;
            st  <= ST_SCAN;
          end else if (pend && glb_en) begin
            idx <= '0;
            st  <= ST_SCAN;
          end else begin
            st  <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R13: a pending request is held unchanged until accepted
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_we) && $stable(mem_wdata));

  assert_quiet_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !wb_valid);

  assert_off_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en && !busy |=> !busy);

  assert_tc_after_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_pulse) |-> $past(wb_valid));

  assert_err_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_pulse) |-> !mem_valid && $past(!mem_valid));

  assert_disable_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_en |-> wb_ctrl[CT_CNT_W-1:0] == '0);
endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  localparam int NCH = 4;
  localparam int CW  = 2;
  localparam int W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0;
  logic kick = 1'b0;
  logic [31:0] req_single = '0, req_burst = '0;
  logic [NCH*W-1:0] ch_src, ch_dst, ch_lli, ch_ctrl, ch_conf;
  logic mem_valid, mem_ready, mem_we;
  logic [W-1:0] mem_addr, mem_wdata, mem_rdata;
  logic [2:0] mem_size;
  logic wb_valid, wb_en, busy;
  logic [CW-1:0] wb_chan;
  logic [W-1:0] wb_src, wb_dst, wb_lli, wb_ctrl;
  logic [NCH-1:0] tc_pulse, err_pulse;

  always #2 clk = ~clk;

  dma_chan_engine #(.NCH(NCH)) dut (.*);

  logic [W-1:0] mem [256];
  logic [W-1:0] r_src[NCH], r_dst[NCH], r_lli[NCH], r_ctrl[NCH], r_conf[NCH];
  logic stall_mode = 1'b0;
  logic [3:0] tick = '0;
  int acc_cnt = 0, tc_cnt = 0, err_cnt = 0, hold_viol = 0, wb_n = 0;
  logic [NCH-1:0] tc_seen = '0, err_seen = '0;
  logic [CW-1:0] wb_log[16];
  logic prev_stall = 1'b0;
  logic [W-1:0] prev_addr = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign mem_ready = !stall_mode || tick[0] && tick[1];
  assign mem_rdata = mem[mem_addr[9:2]];

  always_comb
    for (int i = 0; i < NCH; i++) begin
      ch_src [i*W +: W] = r_src[i];
      ch_dst [i*W +: W] = r_dst[i];
      ch_lli [i*W +: W] = r_lli[i];
      ch_ctrl[i*W +: W] = r_ctrl[i];
      ch_conf[i*W +: W] = r_conf[i];
    end

  always @(posedge clk) begin
    tick <= tick + 1'b1;
    if (prev_stall && (!mem_valid || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
    prev_stall <= mem_valid && !mem_ready;
    prev_addr  <= mem_addr;
    if (mem_valid && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end
    if (wb_valid) begin
      r_src[wb_chan]     <= wb_src;
      r_dst[wb_chan]     <= wb_dst;
      r_lli[wb_chan]     <= wb_lli;
      r_ctrl[wb_chan]    <= wb_ctrl;
      r_conf[wb_chan][0] <= wb_en;
      if (wb_n < 16) wb_log[wb_n] <= wb_chan;
      wb_n <= wb_n + 1;
    end
    if (|tc_pulse)  begin tc_cnt  <= tc_cnt + 1;  tc_seen  <= tc_seen | tc_pulse;  end
    if (|err_pulse) begin err_cnt <= err_cnt + 1; err_seen <= err_seen | err_pulse; end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_state();
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      r_src[i] = '0; r_dst[i] = '0; r_lli[i] = '0; r_ctrl[i] = '0; r_conf[i] = '0;
    end
    acc_cnt = 0; tc_cnt = 0; err_cnt = 0; wb_n = 0; tc_seen = '0; err_seen = '0;
  endtask

  task automatic set_ch(input int c, input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] l, input logic [31:0] ct, input logic [31:0] cf);
    r_src[c] = s; r_dst[c] = d; r_lli[c] = l; r_ctrl[c] = ct; r_conf[c] = cf;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    @(negedge clk) kick = 1'b0;
  endtask

  localparam logic [31:0] W4 = (32'd2 << 18) | (32'd2 << 21);
  localparam logic [31:0] INC = (32'd1 << 26) | (32'd1 << 27);
  localparam logic [31:0] TCB = 32'h8000_0000;

  task automatic t_reset();
    check(!busy && !mem_valid && !wb_valid && tc_pulse == 0 && err_pulse == 0,
          "R1 reset outputs", {busy, mem_valid, wb_valid, tc_pulse, err_pulse}, 0);
  endtask

  task automatic t_disabled();
    clear_state();
    set_ch(0, 32'h100, 32'h200, 0, W4 | INC | 32'd1, 32'd1);
    glb_en = 1'b0;
    pulse_kick();
    wait_idle();
    check(acc_cnt == 0 && !busy, "R2 no access while disabled", acc_cnt, 0);
    @(negedge clk) glb_en = 1'b1;
    repeat (10) @(negedge clk);
    check(acc_cnt == 0, "R2 discarded kick", acc_cnt, 0);
  endtask

  task automatic t_copy();
    logic [31:0] e0, e2;
    clear_state();
    e0 = mem[64]; e2 = mem[66];
    set_ch(0, 32'h100, 32'h200, 0, TCB | (32'd1 << 28) | W4 | INC | 32'd3, 32'd1);
    stall_mode = 1'b1;
    pulse_kick();
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R14 busy during pass", busy, 1);
    wait_idle();
    stall_mode = 1'b0;
    check(mem[128] == e0 && mem[130] == e2, "R7 copied data", mem[130], e2);
    check(r_src[0] == 32'h10C && r_dst[0] == 32'h20C, "R7 addresses stepped", r_src[0], 32'h10C);
    check(r_ctrl[0] == (TCB | (32'd1 << 28) | W4 | INC), "R8 count zero upper kept", r_ctrl[0], TCB | (32'd1 << 28) | W4 | INC);
    check(r_conf[0][0] == 1'b0, "R10 channel disabled", r_conf[0], 0);
    check(tc_cnt == 1 && tc_seen == 4'b0001, "R11 one tc pulse ch0", tc_cnt, 1);
    check(acc_cnt == 6 && wb_n == 3, "R8 one write-back per element", wb_n, 3);
    check(hold_viol == 0, "R13 request held under stall", hold_viol, 0);
  endtask

  task automatic t_halfword();
    logic [31:0] e;
    clear_state();
    e = mem[96];
    set_ch(3, 32'h180, 32'h280, 0, (32'd1 << 18) | (32'd1 << 21) | (32'd1 << 26) | 32'd2, 32'd1);
    pulse_kick();
    wait_idle();
    check(r_src[3] == 32'h184 && r_dst[3] == 32'h280, "R7 step 2 src only", r_src[3], 32'h184);
    check(mem[160] == e && tc_cnt == 0, "R7 last element at fixed dst", mem[160], e);
  endtask

  task automatic t_priority();
    clear_state();
    set_ch(2, 32'h108, 32'h220, 0, W4 | INC | 32'd2, 32'd1);
    set_ch(1, 32'h100, 32'h210, 0, W4 | INC | 32'd2, 32'd1);
    pulse_kick();
    wait_idle();
    check(wb_n == 4 && wb_log[0] == 1 && wb_log[1] == 1 && wb_log[2] == 2 && wb_log[3] == 2,
          "R4 order 1,1,2,2", {wb_log[0], wb_log[1], wb_log[2], wb_log[3]}, 8'b01011010);
  endtask

  task automatic t_halt();
    clear_state();
    set_ch(0, 32'h100, 32'h200, 0, W4 | INC | 32'd2, 32'd1 | (32'd1 << 18));
    set_ch(1, 32'h100, 32'h200, 0, W4 | INC, 32'd1);
    pulse_kick();
    wait_idle();
    check(acc_cnt == 0 && r_ctrl[0][11:0] == 12'd2, "R3 halted and zero-count skip", acc_cnt, 0);
  endtask

  task automatic t_flow();
    clear_state();
    set_ch(0, 32'h100, 32'h200, 0, W4 | INC | 32'd1, 32'd1 | (32'd1 << 11) | (32'd5 << 6));
    pulse_kick();
    wait_idle();
    check(acc_cnt == 0, "R5 flow1 waits for dst request", acc_cnt, 0);
    @(negedge clk) req_burst[5] = 1'b1;
    wait_idle();
    check(acc_cnt == 2 && r_conf[0][0] == 1'b0, "R12 request change starts, R5 burst line", acc_cnt, 2);
    clear_state();
    req_burst = '0;
    wait_idle();
    set_ch(1, 32'h100, 32'h200, 0, W4 | INC | 32'd1, 32'd1 | (32'd3 << 11) | (32'd2 << 1) | (32'd3 << 6));
    @(negedge clk) req_single[2] = 1'b1;
    wait_idle();
    check(acc_cnt == 0, "R5 flow3 needs both", acc_cnt, 0);
    @(negedge clk) req_single[3] = 1'b1;
    wait_idle();
    check(acc_cnt == 2, "R5 flow3 both present", acc_cnt, 2);
    req_single = '0;
    wait_idle();
  endtask

  task automatic t_bad_flow();
    clear_state();
    set_ch(2, 32'h100, 32'h200, 0, W4 | INC | 32'd1, 32'd1 | (32'd5 << 11));
    pulse_kick();
    wait_idle();
    check(err_cnt >= 1 && err_seen == 4'b0100 && acc_cnt == 0, "R6 error pulse no access", err_seen, 4'b0100);
  endtask

  task automatic t_link();
    logic [31:0] e0, e1, e2;
    clear_state();
    e0 = mem[72]; e1 = mem[80]; e2 = mem[81];
    mem[192] = 32'h140; mem[193] = 32'h240; mem[194] = 32'h0;
    mem[195] = TCB | W4 | INC | 32'd2;
    set_ch(0, 32'h120, 32'h230, 32'h300, W4 | INC | 32'd1, 32'd1);
    pulse_kick();
    wait_idle();
    check(mem[140] == e0 && mem[144] == e1 && mem[145] == e2, "R9 chained data", mem[145], e2);
    check(r_src[0] == 32'h148 && r_dst[0] == 32'h248 && r_lli[0] == 0, "R9 descriptor loaded", r_src[0], 32'h148);
    check(acc_cnt == 10 && tc_cnt == 1 && r_conf[0][0] == 1'b0, "R11 tc from second descriptor only", tc_cnt, 1);
  endtask

  task automatic t_rescan();
    logic [31:0] e;
    clear_state();
    e = mem[88];
    set_ch(1, 32'h100, 32'h2C0, 0, W4 | INC | 32'd4, 32'd1);
    stall_mode = 1'b1;
    pulse_kick();
    repeat (6) @(negedge clk);
    set_ch(0, 32'h160, 32'h2F0, 0, W4 | INC | 32'd1, 32'd1);
    pulse_kick();
    wait_idle();
    stall_mode = 1'b0;
    check(r_conf[0][0] == 1'b0 && mem[188] == e && r_conf[1][0] == 1'b0, "R12 extra pass serves ch0", mem[188], e);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i;
    for (int i = 0; i < NCH; i++) set_ch(i, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_disabled();
    t_copy();
    t_halfword();
    t_priority();
    t_halt();
    t_flow();
    t_bad_flow();
    t_link();
    t_rescan();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule